// File: doc/BRIEF.md
# Address-Matched Interrupt Injector

This block sits beside a processor core in a test harness and drives the core's external interrupt and abort request lines at a chosen moment. Software running on the core under test programs a target fetch address, a cycle delay and a set of request sources through four word registers, then arms the block. No stimulus from outside the chip is needed. The block watches the core's fetch port. When a valid fetch carries the target address, it waits the programmed number of cycles and then raises the selected request lines. This lets a request land in any pipeline stage of the chosen instruction.

Two injection styles exist. In single-source mode only one request line is raised, so the core sees one request before it takes any other. In multi-source mode every selected line rises in the same cycle, so several requests are pending before the core answers any of them. Each arming yields one injection. A raised line drops when the core acknowledges it or when a fixed hold limit runs out. A sticky flag records that an injection took place.

Top module: `fetch_match_injector`

## Requirements
- R1: After reset all request lines are low and the control word reads zero.
- R2: The registers read back what was written: target at byte offset 0x0, delay at 0x4 (low DLY_W bits), source mask at 0x8 (low NSRC bits), control at 0xC. The control bits are: bit 0 = armed (write 1 to arm, write 0 to disarm), bit 1 = done (sticky, write 1 to clear), bit 2 = multi-source mode.
- R3: No line rises while the block is armed unless `fetch_valid` is high and `fetch_addr` equals the target.
- R4: With a delay D > 0, lines are low in the D-1 cycles after the match cycle and high in cycle D after it.
- R5: With a delay of zero, lines rise combinationally in the match cycle itself.
- R6: In single-source mode (control bit 2 = 0), only the lowest-numbered set mask bit is raised. The line encoding is: bit 0 IRQ, bit 1 FIQ, bit 2 prefetch abort, bit 3 data abort.
- R7: In multi-source mode (control bit 2 = 1), every set mask bit is raised in the same cycle.
- R8: An injection disarms the block. The armed bit then reads 0, and a later matching fetch raises nothing.
- R9: The done bit reads 1 after an injection until software writes control with bit 1 set.
- R10: An acknowledge pulse on a raised line drops that line in the next cycle. Other raised lines stay high.
- R11: A line that is never acknowledged stays high for exactly TMO cycles, counting the cycle in which it rises.
- R12: Writing control with bit 0 = 0 while the block is armed or counting cancels the pending injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| fetch_valid | input | 1 | Core fetch address is valid this cycle |
| fetch_addr | input | AW | Core instruction fetch address |
| int_ack | input | NSRC | Per-line acknowledge from the core |
| int_line | output | NSRC | Request lines driven into the core |

## Verification
The hardest case to reach from the ports is the exact landing cycle. The lines must rise D cycles after the match and not one cycle early. In the delay-zero case they must rise in the match cycle itself, before any register has captured the match. The bench drives a single-cycle matching fetch and samples the lines in every following cycle, for several delays including zero. Partial acknowledges in multi-source mode are also hard to reach. The bench acknowledges one line at a time while the other is still held, and separately lets a line run out its full hold limit.

// File: rtl/inj_pkg.sv
package inj_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } trig_st_e;

    localparam logic [1:0] WSEL_TGT  = 2'd0;
    localparam logic [1:0] WSEL_DLY  = 2'd1;
    localparam logic [1:0] WSEL_MASK = 2'd2;
    localparam logic [1:0] WSEL_CTRL = 2'd3;

    localparam int CTL_ARM  = 0;
    localparam int CTL_DONE = 1;
    localparam int CTL_CONC = 2;
endpackage

// File: rtl/inj_regs.sv
module inj_regs
    import inj_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DLY_W = 8,
    parameter int NSRC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             fire_evt,
    input  logic             armed,
    output logic [AW-1:0]    tgt,
    output logic [DLY_W-1:0] dly,
    output logic [NSRC-1:0]  mask,
    output logic             conc,
    output logic             arm_set,
    output logic             arm_clr
);
    typedef struct packed {
        logic [AW-1:0]    tgt;
        logic [DLY_W-1:0] dly;
        logic [NSRC-1:0]  mask;
        logic             conc;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;
    logic  ctrl_wr;

    assign ctrl_wr = we && (addr[3:2] == WSEL_CTRL);

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr[3:2])
                WSEL_TGT:  r_d.tgt  = wdata[AW-1:0];
                WSEL_DLY:  r_d.dly  = wdata[DLY_W-1:0];
                WSEL_MASK: r_d.mask = wdata[NSRC-1:0];
                default: begin
                    r_d.conc = wdata[CTL_CONC];
                    if (wdata[CTL_DONE]) r_d.done = 1'b0;
                end
            endcase
        end
        if (fire_evt) r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr[3:2])
            WSEL_TGT:  rdata[AW-1:0]    = r_q.tgt;
            WSEL_DLY:  rdata[DLY_W-1:0] = r_q.dly;
            WSEL_MASK: rdata[NSRC-1:0]  = r_q.mask;
            default: begin
                rdata[CTL_ARM]  = armed;
                rdata[CTL_DONE] = r_q.done;
                rdata[CTL_CONC] = r_q.conc;
            end
        endcase
    end

    assign tgt     = r_q.tgt;
    assign dly     = r_q.dly;
    assign mask    = r_q.mask;
    assign conc    = r_q.conc;
    assign arm_set = ctrl_wr && wdata[CTL_ARM];
    assign arm_clr = ctrl_wr && !wdata[CTL_ARM];

    // R9: an injection leaves the done flag set
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fire_evt |=> r_q.done);
endmodule

// File: rtl/inj_trigger.sv
module inj_trigger
    import inj_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DLY_W = 8,
    parameter int NSRC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    fetch_addr,
    input  logic [AW-1:0]    tgt,
    input  logic [DLY_W-1:0] dly,
    input  logic [NSRC-1:0]  mask,
    input  logic             conc,
    input  logic             arm_set,
    input  logic             arm_clr,
    output logic [NSRC-1:0]  fire_vec,
    output logic             fire_evt,
    output logic             armed
);
    typedef struct packed {
        trig_st_e         st;
        logic [DLY_W-1:0] cnt;
    } trig_t;

    trig_t           t_q, t_d;
    logic            hit;
    logic [NSRC-1:0] sel;

    assign hit = fetch_valid && (fetch_addr == tgt);
    assign sel = conc ? mask : (mask & (~mask + 1'b1));

    always_comb begin
        t_d      = t_q;
        fire_evt = 1'b0;
        case (t_q.st)
            ST_ARMED: begin
                if (hit) begin
                    if (dly == '0) begin
                        fire_evt = 1'b1;
                        t_d.st   = ST_IDLE;
                    end else begin
                        t_d.st  = ST_COUNT;
                        t_d.cnt = dly;
                    end
                end
            end
            ST_COUNT: begin
                if (t_q.cnt == {{(DLY_W-1){1'b0}}, 1'b1}) begin
                    fire_evt = 1'b1;
                    t_d.st   = ST_IDLE;
                    t_d.cnt  = '0;
                end else begin
                    t_d.cnt = t_q.cnt - 1'b1;
                end
            end
            default: ;
        endcase
        if (arm_clr) t_d.st = ST_IDLE;
        if (arm_set) t_d.st = ST_ARMED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{st: ST_IDLE, cnt: '0};
        else        t_q <= t_d;
    end

    assign fire_vec = fire_evt ? sel : '0;
    assign armed    = (t_q.st != ST_IDLE);

    // R8: an injection leaves the block disarmed unless re-armed that cycle
    a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_evt && !arm_set) |=> (t_q.st == ST_IDLE));
    // R6: single-source mode raises at most one line
    a_r6_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        !conc |-> $onehot0(fire_vec));
    // R3: nothing fires from idle
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == ST_IDLE) |-> !fire_evt);
    // R4: the delay counter is never zero while counting
    a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st == ST_COUNT) |-> (t_q.cnt != '0));
endmodule

// File: rtl/inj_drive.sv
module inj_drive #(
    parameter int NSRC = 4,
    parameter int TMO  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] fire_vec,
    input  logic [NSRC-1:0] ack,
    output logic [NSRC-1:0] lines
);
    localparam int AGE_W = $clog2(TMO + 1);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TMO - 1);

    typedef struct packed {
        logic [NSRC-1:0]  held;
        logic [AGE_W-1:0] age;
    } drv_t;

    drv_t d_q, d_d;

    always_comb begin
        d_d = d_q;
        if (d_q.held != '0) begin
            if (d_q.age == AGE_LAST) begin
                d_d.held = '0;
                d_d.age  = '0;
            end else begin
                d_d.held = d_q.held & ~ack;
                d_d.age  = d_q.age + 1'b1;
            end
        end
        if (fire_vec != '0) begin
            d_d.held = d_d.held | fire_vec;
            d_d.age  = AGE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign lines = d_q.held | fire_vec;

    // R10: an acknowledged line is gone in the next cycle unless re-fired
    a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((fire_vec == '0) && ((d_q.held & ack) != '0)) |=> ((d_q.held & $past(ack)) == '0));
    // R11: the hold age stays inside the limit
    a_r11_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.held != '0) |-> (d_q.age <= AGE_LAST));
endmodule

// File: rtl/fetch_match_injector.sv
module fetch_match_injector #(
    parameter int AW    = 32,
    parameter int DLY_W = 8,
    parameter int NSRC  = 4,
    parameter int TMO   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [3:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    input  logic            fetch_valid,
    input  logic [AW-1:0]   fetch_addr,
    input  logic [NSRC-1:0] int_ack,
    output logic [NSRC-1:0] int_line
);
    logic [AW-1:0]    tgt;
    logic [DLY_W-1:0] dly;
    logic [NSRC-1:0]  mask;
    logic             conc, arm_set, arm_clr, armed, fire_evt;
    logic [NSRC-1:0]  fire_vec;

    inj_regs #(.AW(AW), .DLY_W(DLY_W), .NSRC(NSRC)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .fire_evt(fire_evt),
        .armed(armed), .tgt(tgt), .dly(dly), .mask(mask), .conc(conc),
        .arm_set(arm_set), .arm_clr(arm_clr)
    );

    inj_trigger #(.AW(AW), .DLY_W(DLY_W), .NSRC(NSRC)) trig_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .tgt(tgt), .dly(dly), .mask(mask),
        .conc(conc), .arm_set(arm_set), .arm_clr(arm_clr),
        .fire_vec(fire_vec), .fire_evt(fire_evt), .armed(armed)
    );

    inj_drive #(.NSRC(NSRC), .TMO(TMO)) drv_i (
        .clk(clk), .rst_n(rst_n), .fire_vec(fire_vec), .ack(int_ack),
        .lines(int_line)
    );

    // R7: in multi-source mode the raised set equals the mask
    a_r7_all_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_evt && conc) |-> ((int_line & mask) == mask));
endmodule

// File: tb/fetch_match_injector_tb_top.sv
module fetch_match_injector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [3:0]  int_ack = '0;
    logic [3:0]  int_line;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fetch_match_injector dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .int_ack(int_ack), .int_line(int_line)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // programs and arms; returns at a negedge with arming in effect
    task automatic setup(logic [31:0] t, logic [7:0] dl, logic [3:0] m, bit cc);
        wr(4'h0, t);
        wr(4'h4, {24'd0, dl});
        wr(4'h8, {28'd0, m});
        wr(4'hC, {29'd0, cc, 1'b1, 1'b1});
    endtask

    // drive one matching fetch starting at the next negedge, sample #1 later
    task automatic hit(logic [31:0] a);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a;
        #1;
    endtask

    task automatic step;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_addr = '0;
        #1;
    endtask

    task automatic cleanup;
        @(negedge clk);
        fetch_valid = 1'b0; int_ack = 4'hF;
        @(negedge clk);
        int_ack = 4'h0;
        wr(4'hC, 32'h2);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 lines after reset", {28'd0, int_line}, 32'h0);
        rd(4'hC, v);
        check("R1 control after reset", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(4'h0, 32'hDEAD_BEE0);
        wr(4'h4, 32'h0000_0107);
        wr(4'h8, 32'h0000_00F9);
        wr(4'hC, 32'h4);
        rd(4'h0, v); check("R2 target readback", v, 32'hDEAD_BEE0);
        rd(4'h4, v); check("R2 delay readback", v, 32'h07);
        rd(4'h8, v); check("R2 mask readback", v, 32'h9);
        rd(4'hC, v); check("R2 control readback", v, 32'h4);
    endtask

    task automatic t_nofire;
        logic [31:0] v;
        setup(32'h100, 8'd0, 4'h1, 1'b0);
        hit(32'h104);
        check("R3 wrong address", {28'd0, int_line}, 32'h0);
        fetch_valid = 1'b0; fetch_addr = 32'h100;
        #1;
        check("R3 address without valid", {28'd0, int_line}, 32'h0);
        step;
        check("R3 still quiet", {28'd0, int_line}, 32'h0);
        rd(4'hC, v);
        check("R3 still armed", v & 32'h1, 32'h1);
        cleanup;
    endtask

    task automatic t_delay(logic [7:0] dl);
        setup(32'h200, dl, 4'h2, 1'b0);
        hit(32'h200);
        check("R4 low at match", {28'd0, int_line}, 32'h0);
        for (int k = 1; k < int'(dl); k++) begin
            step;
            check("R4 low before delay", {28'd0, int_line}, 32'h0);
        end
        step;
        check("R4 high at delay", {28'd0, int_line}, 32'h2);
        cleanup;
    endtask

    task automatic t_zero;
        setup(32'h300, 8'd0, 4'h8, 1'b0);
        hit(32'h300);
        check("R5 same-cycle rise", {28'd0, int_line}, 32'h8);
        cleanup;
    endtask

    task automatic t_single;
        setup(32'h400, 8'd0, 4'hC, 1'b0);
        hit(32'h400);
        check("R6 lowest source only", {28'd0, int_line}, 32'h4);
        step;
        check("R6 held single", {28'd0, int_line}, 32'h4);
        cleanup;
    endtask

    task automatic t_multi;
        setup(32'h500, 8'd2, 4'hB, 1'b1);
        hit(32'h500);
        step;
        check("R7 none before delay", {28'd0, int_line}, 32'h0);
        step;
        check("R7 all sources together", {28'd0, int_line}, 32'hB);
        cleanup;
    endtask

    task automatic t_oneshot_done;
        logic [31:0] v;
        setup(32'h600, 8'd0, 4'h1, 1'b0);
        hit(32'h600);
        step;
        rd(4'hC, v);
        check("R8 disarmed after fire", v & 32'h1, 32'h0);
        check("R9 done set", v & 32'h2, 32'h2);
        @(negedge clk); int_ack = 4'hF;
        @(negedge clk); int_ack = 4'h0;
        hit(32'h600);
        check("R8 second match ignored", {28'd0, int_line}, 32'h0);
        step;
        rd(4'hC, v);
        check("R9 done still set", v & 32'h2, 32'h2);
        wr(4'hC, 32'h2);
        rd(4'hC, v);
        check("R9 done cleared by write", v & 32'h2, 32'h0);
    endtask

    task automatic t_ack;
        setup(32'h700, 8'd0, 4'h3, 1'b1);
        hit(32'h700);
        check("R10 both raised", {28'd0, int_line}, 32'h3);
        @(negedge clk);
        fetch_valid = 1'b0; int_ack = 4'h1;
        #1;
        check("R10 held during ack", {28'd0, int_line}, 32'h3);
        @(negedge clk);
        int_ack = 4'h2;
        #1;
        check("R10 acked line drops, other stays", {28'd0, int_line}, 32'h2);
        @(negedge clk);
        int_ack = 4'h0;
        #1;
        check("R10 all released", {28'd0, int_line}, 32'h0);
        cleanup;
    endtask

    task automatic t_timeout;
        int high = 0;
        setup(32'h800, 8'd0, 4'h1, 1'b0);
        hit(32'h800);
        if (int_line[0]) high++;
        for (int k = 0; k < 80; k++) begin
            step;
            if (int_line[0]) high++;
        end
        check("R11 hold length", high, 64);
        cleanup;
    endtask

    task automatic t_cancel;
        logic [31:0] v;
        setup(32'h900, 8'd3, 4'h1, 1'b0);
        wr(4'hC, 32'h0);
        rd(4'hC, v);
        check("R12 armed bit cleared", v & 32'h1, 32'h0);
        hit(32'h900);
        for (int k = 0; k < 4; k++) step;
        check("R12 no fire after cancel", {28'd0, int_line}, 32'h0);
        setup(32'h900, 8'd3, 4'h1, 1'b0);
        hit(32'h900);
        step;
        wr(4'hC, 32'h0);
        for (int k = 0; k < 3; k++) step;
        check("R12 counting cancelled", {28'd0, int_line}, 32'h0);
        cleanup;
    endtask

    initial begin
        #23;
        t_reset;
        rst_n = 1'b1;
        t_regs;
        t_nofire;
        t_delay(8'd1);
        t_delay(8'd3);
        t_delay(8'd6);
        t_zero;
        t_single;
        t_multi;
        t_oneshot_done;
        t_ack;
        t_timeout;
        t_cancel;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule